// File: doc/BRIEF.md
# Strobe-Controlled FIFO with Read and Write Flow-Through

This block is a first-in first-out buffer, 9 bits wide by default, driven by two active-low strobes: one for writes and one for reads. Both strobes are asynchronous to the system clock. Each one goes through a two-flop synchronizer, and its edges are detected on the system clock. A write is taken on the falling edge of the write strobe. A read is started on the falling edge of the read strobe. The read word appears on the data output a set number of cycles later, together with an output-enable that stands in for a three-state driver. That enable drops a set number of cycles after the read strobe rises. Two active-low flags, empty and full, are registered on the clock.

The buffer handles two boundary cases in which a strobe is held low across the empty or full limit:

- **Read flow-through.** The read strobe is held low on an empty buffer. The next word written is passed straight to the output. The empty flag goes inactive for one cycle and then returns.
- **Write flow-through.** The write strobe is held low on a full buffer. The next read frees a slot and the held word is stored. The full flag goes inactive for one cycle and then returns.

After either case, the strobe has to be released and pressed again before it acts on the buffer again.

Top module: `sfifo_flowthru`

## Requirements
- R1: While reset is low, and on the first clock after it is released, empty_n is 0, full_n is 1 and dout_oe is 0.
- R2: Each falling edge of wr_n on a non-full buffer stores din. empty_n goes high. Words are read out in the order they were written.
- R3: A falling edge of rd_n on a non-empty buffer puts the oldest word on dout. dout_oe rises on the (ACC_DELAY+3)th rising clock edge after rd_n falls.
- R4: dout_oe falls on the (HZ_DELAY+3)th rising clock edge after rd_n rises.
- R5: After DEPTH writes, full_n is 0. A write strobe pressed and released while the buffer is full, with no read in between, is discarded and never appears on dout.
- R6: A read strobe pressed and released while the buffer is empty, with no write in between, changes nothing. empty_n stays 0, dout_oe stays 0, and the next word written is the next word read.
- R7: With rd_n held low on an empty buffer, the next write drives that word onto dout with dout_oe high, without a further read strobe. empty_n is high for exactly one cycle.
- R8: Further writes while rd_n stays low are stored and raise empty_n. dout and dout_oe stay unchanged.
- R9: After rd_n is raised, the words stored during the held read come out one per read strobe, in order, and the buffer ends empty.
- R10: With wr_n held low on a full buffer, the next read stores the word then on din. full_n is high for exactly one cycle. The stored word is read out after the words already in the buffer.
- R11: After a write flow-through, another read with wr_n still held low leaves full_n at 1 and stores nothing. Only a new falling edge of wr_n stores the next word.
- R12: empty_n and full_n are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| din | input | DW | Write data, held stable while wr_n is low |
| dout | output | DW | Read data, meaningful while dout_oe is high |
| dout_oe | output | 1 | Output enable (high means driven) |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |

## Verification
The assertions assume that each strobe stays at one level for at least a few clock cycles, so every edge passes through the synchronizer and is seen exactly once. They also assume that din does not change while wr_n is low. The stimulus holds each strobe level for six or more cycles and changes din only while wr_n is high. It also waits long enough for dout_oe to drop before starting the next read, so every rise of the enable marks exactly one word.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    // Per-strobe event bundle produced by the synchronizer
    typedef struct packed {
        logic active;   // synchronized strobe is low
        logic lead;     // high-to-low transition seen this cycle
        logic trail;    // low-to-high transition seen this cycle
    } strobe_ev_t;

    localparam int unsigned NUM_STROBES = 2;
    localparam int unsigned STB_WR      = 0;
    localparam int unsigned STB_RD      = 1;

endpackage

// File: rtl/sfifo_strobe_sync.sv
module sfifo_strobe_sync
    import sfifo_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_n,
    output strobe_ev_t ev
);
    localparam int unsigned CW = STAGES + 1;

    logic [CW-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CW-2:0], strobe_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    always_comb begin
        ev.active = ~chain_q[STAGES-1];
        ev.lead   = chain_q[STAGES] & ~chain_q[STAGES-1];
        ev.trail  = ~chain_q[STAGES] & chain_q[STAGES-1];
    end
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int unsigned DW    = 9,
    parameter int unsigned DEPTH = 512,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int unsigned DW        = 9,
    parameter int unsigned DEPTH     = 512,
    parameter int unsigned ACC_DELAY = 2,
    parameter int unsigned HZ_DELAY  = 1,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned PW       = AW + 1,
    localparam int unsigned MAXD     = (ACC_DELAY > HZ_DELAY) ? ACC_DELAY : HZ_DELAY,
    localparam int unsigned CW       = $clog2(MAXD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_ev_t    wr_ev,
    input  strobe_ev_t    rd_ev,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [AW-1:0] mem_raddr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    output logic          empty_n,
    output logic          full_n
);
    localparam logic [PW-1:0] FULL_GAP = {1'b1, {AW{1'b0}}};
    localparam logic [CW-1:0] ACC_LD   = CW'(ACC_DELAY);
    localparam logic [CW-1:0] HZ_LD    = CW'(HZ_DELAY);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic          empty_n;
        logic          full_n;
        logic          rd_hold;   // read strobe low on empty buffer, waiting for a word
        logic          wr_hold;   // write strobe low on full buffer, waiting for a slot
        logic          pass_pend; // flow-through word written last cycle
        logic [CW-1:0] acc_cnt;
        logic [CW-1:0] hz_cnt;
        logic [DW-1:0] stage;
        logic [DW-1:0] dout;
        logic          oe;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  is_empty, is_full, wr_go, rd_go;

    always_comb begin
        st_d     = st_q;
        is_empty = (st_q.wptr == st_q.rptr);
        is_full  = ((st_q.wptr ^ st_q.rptr) == FULL_GAP);
        wr_go    = 1'b0;
        rd_go    = 1'b0;

        // write side: strobe edge, or a held strobe waiting on a freed slot
        if (wr_ev.lead) begin
            if (!is_full) wr_go = 1'b1;
            else          st_d.wr_hold = 1'b1;
        end
        if (st_q.wr_hold && !is_full) begin
            wr_go        = 1'b1;
            st_d.wr_hold = 1'b0;
        end
        if (wr_ev.trail) st_d.wr_hold = 1'b0;
        if (wr_go) st_d.wptr = st_q.wptr + 1'b1;

        // read side: strobe edge, or a word arriving under a held strobe
        if (rd_ev.lead) begin
            if (!is_empty) rd_go = 1'b1;
            else           st_d.rd_hold = 1'b1;
        end
        st_d.pass_pend = 1'b0;
        if (st_q.rd_hold && wr_go && is_empty) begin
            st_d.pass_pend = 1'b1;
            st_d.rd_hold   = 1'b0;
        end
        if (st_q.pass_pend) rd_go = 1'b1;
        if (rd_ev.trail) st_d.rd_hold = 1'b0;

        // access delay counter
        if (st_q.acc_cnt != '0) begin
            st_d.acc_cnt = st_q.acc_cnt - 1'b1;
            if (st_q.acc_cnt == CW'(1)) begin
                st_d.dout = st_q.stage;
                st_d.oe   = 1'b1;
            end
        end
        // release delay counter
        if (st_q.hz_cnt != '0) begin
            st_d.hz_cnt = st_q.hz_cnt - 1'b1;
            if (st_q.hz_cnt == CW'(1)) st_d.oe = 1'b0;
        end
        if (rd_ev.trail) st_d.hz_cnt = HZ_LD;

        if (rd_go) begin
            st_d.rptr    = st_q.rptr + 1'b1;
            st_d.stage   = mem_rdata;
            st_d.acc_cnt = ACC_LD;
        end

        st_d.empty_n = (st_d.wptr != st_d.rptr);
        st_d.full_n  = ((st_d.wptr ^ st_d.rptr) != FULL_GAP);

        mem_we    = wr_go;
        mem_waddr = st_q.wptr[AW-1:0];
        mem_raddr = st_q.rptr[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.empty_n <= 1'b0;
            st_q.full_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout    = st_q.dout;
    assign dout_oe = st_q.oe;
    assign empty_n = st_q.empty_n;
    assign full_n  = st_q.full_n;
endmodule

// File: rtl/sfifo_flowthru.sv
module sfifo_flowthru
    import sfifo_pkg::*;
#(
    parameter int unsigned DW          = 9,
    parameter int unsigned DEPTH       = 512,
    parameter int unsigned ACC_DELAY   = 2,
    parameter int unsigned HZ_DELAY    = 1,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    output logic          empty_n,
    output logic          full_n
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic [NUM_STROBES-1:0] strobe_raw;
    strobe_ev_t             strobe_ev [NUM_STROBES];
    logic                   mem_we;
    logic [AW-1:0]          mem_waddr, mem_raddr;
    logic [DW-1:0]          mem_rdata;

    assign strobe_raw[STB_WR] = wr_n;
    assign strobe_raw[STB_RD] = rd_n;

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_sync
        sfifo_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_n (strobe_raw[g]),
            .ev       (strobe_ev[g])
        );
    end

    sfifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (din),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    sfifo_ctrl #(
        .DW(DW), .DEPTH(DEPTH), .ACC_DELAY(ACC_DELAY), .HZ_DELAY(HZ_DELAY)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ev     (strobe_ev[STB_WR]),
        .rd_ev     (strobe_ev[STB_RD]),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_raddr (mem_raddr),
        .mem_rdata (mem_rdata),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .empty_n   (empty_n),
        .full_n    (full_n)
    );
endmodule

// File: rtl/sfifo_flowthru_chk.sv
module sfifo_flowthru_chk #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic wr_n,
    input logic dout_oe,
    input logic empty_n,
    input logic full_n
);
    // R1: reset state still visible on the first clock after release
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!empty_n && full_n && !dout_oe));

    // R12: the two flags never both asserted
    assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!empty_n && !full_n));

    // R5: full can only be reached from a non-empty buffer
    assert_full_from_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_n) |-> $past(empty_n));

    // R6: empty can only be reached from a non-full buffer
    assert_empty_from_nonfull_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty_n) |-> $past(full_n));

    // R2: leaving empty needs a write strobe seen low through the synchronizer
    assert_leave_empty_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty_n) |-> !$past(wr_n, SYNC_STAGES + 1));
endmodule

bind sfifo_flowthru sfifo_flowthru_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_n    (wr_n),
    .dout_oe (dout_oe),
    .empty_n (empty_n),
    .full_n  (full_n)
);

// File: tb/sfifo_flowthru_tb.sv
module sfifo_flowthru_tb;
    localparam int unsigned DW    = 9;
    localparam int unsigned DEPTH = 8;
    localparam int unsigned ACC   = 2;
    localparam int unsigned HZ    = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_n = 1'b1;
    logic          rd_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe, empty_n, full_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [DW-1:0] exp_q[$];
    logic oe_prev = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sfifo_flowthru #(.DW(DW), .DEPTH(DEPTH), .ACC_DELAY(ACC), .HZ_DELAY(HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .din(din),
        .dout(dout), .dout_oe(dout_oe), .empty_n(empty_n), .full_n(full_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input logic [DW-1:0] v, input bit expect_store);
        din = v;
        if (expect_store) exp_q.push_back(v);
        wr_n = 1'b0; cyc(6);
        wr_n = 1'b1; cyc(6);
    endtask

    task automatic take();
        rd_n = 1'b0; cyc(8);
        rd_n = 1'b1; cyc(8);
    endtask

    // scoreboard monitor: every rise of the enable delivers one word (R2, R9)
    always @(negedge clk) begin
        if (rst_n && dout_oe && !oe_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected word", int'(dout), 0);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                check(dout == e, "R2/R9 read order", int'(dout), int'(e));
            end
        end
        oe_prev = dout_oe;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        cyc(5);
        check(!empty_n && full_n && !dout_oe, "R1 reset state",
              {empty_n, full_n, dout_oe}, 3'b010);
        rst_n = 1'b1;
        @(negedge clk);
        check(!empty_n && full_n && !dout_oe, "R1 after release",
              {empty_n, full_n, dout_oe}, 3'b010);

        // R2 / R3 / R4: single word, access and release timing
        put(9'h0A5, 1'b1);
        check(empty_n == 1'b1, "R2 empty_n after write", empty_n, 1);
        rd_n = 1'b0;
        cyc(ACC + 2);
        check(dout_oe == 1'b0, "R3 oe before access delay", dout_oe, 0);
        cyc(1);
        check(dout_oe == 1'b1, "R3 oe at access delay", dout_oe, 1);
        check(dout == 9'h0A5, "R3 dout value", dout, 9'h0A5);
        cyc(5);
        rd_n = 1'b1;
        cyc(HZ + 2);
        check(dout_oe == 1'b1, "R4 oe before release delay", dout_oe, 1);
        cyc(1);
        check(dout_oe == 1'b0, "R4 oe at release delay", dout_oe, 0);
        cyc(8);
        check(empty_n == 1'b0, "R2 empty after read", empty_n, 0);

        // R2: order over several words
        put(9'h111, 1'b1); put(9'h022, 1'b1); put(9'h1F3, 1'b1);
        take(); take(); take();
        check(empty_n == 1'b0, "R2 empty after draining", empty_n, 0);

        // R6: read strobe on empty is ignored
        rd_n = 1'b0;
        cnt = 0;
        for (int i = 0; i < 8; i++) begin @(negedge clk); if (dout_oe || empty_n) cnt++; end
        rd_n = 1'b1; cyc(8);
        check(cnt == 0, "R6 no activity on empty read", cnt, 0);
        put(9'h0C7, 1'b1);
        take();
        check(empty_n == 1'b0, "R6 empty after follow-up read", empty_n, 0);

        // R5: fill, extra write discarded
        for (int i = 0; i < DEPTH; i++) put(DW'(9'h100 + i), 1'b1);
        check(full_n == 1'b0, "R5 full after DEPTH writes", full_n, 0);
        put(9'h1EE, 1'b0);
        check(full_n == 1'b0 && empty_n == 1'b1, "R5 still full after ignored write",
              {full_n, empty_n}, 2'b01);
        for (int i = 0; i < DEPTH; i++) take();
        check(empty_n == 1'b0 && exp_q.size() == 0, "R5 drained without extra word",
              exp_q.size(), 0);

        // R7: read flow-through
        rd_n = 1'b0; cyc(8);
        din = 9'h1C3; exp_q.push_back(9'h1C3);
        wr_n = 1'b0;
        cnt = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); if (empty_n) cnt++; end
        check(cnt == 1, "R7 empty_n pulse width", cnt, 1);
        check(dout_oe == 1'b1 && dout == 9'h1C3, "R7 word passed to output", dout, 9'h1C3);
        wr_n = 1'b1; cyc(6);

        // R8: writes under held read
        put(9'h0AA, 1'b1); put(9'h155, 1'b1);
        check(empty_n == 1'b1, "R8 empty_n raised", empty_n, 1);
        check(dout_oe == 1'b1 && dout == 9'h1C3, "R8 output unchanged", dout, 9'h1C3);

        // R9: release, then normal reads
        rd_n = 1'b1; cyc(8);
        check(dout_oe == 1'b0, "R9 output released", dout_oe, 0);
        take(); take();
        check(empty_n == 1'b0 && exp_q.size() == 0, "R9 empty after remaining words",
              exp_q.size(), 0);

        // R10: write flow-through
        for (int i = 0; i < DEPTH; i++) put(DW'(9'h040 + i), 1'b1);
        din = 9'h0EE; exp_q.push_back(9'h0EE);
        wr_n = 1'b0; cyc(8);
        check(full_n == 1'b0, "R10 full before read", full_n, 0);
        rd_n = 1'b0;
        cnt = 0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); if (full_n) cnt++; end
        check(cnt == 1, "R10 full_n pulse width", cnt, 1);
        rd_n = 1'b1; cyc(8);
        check(full_n == 1'b0, "R10 full after flow-through", full_n, 0);

        // R11: held strobe does not store again
        din = 9'h0DD;
        take();
        check(full_n == 1'b1, "R11 no store with held strobe", full_n, 1);
        wr_n = 1'b1; cyc(6);
        put(9'h0DD, 1'b1);
        check(full_n == 1'b0, "R11 store on new strobe edge", full_n, 0);
        for (int i = 0; i < DEPTH; i++) take();
        check(empty_n == 1'b0 && exp_q.size() == 0, "R10 R11 all words drained in order",
              exp_q.size(), 0);
        check(full_n == 1'b1, "R12 flags consistent at end", full_n, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule